// File: doc/BRIEF.md
# Serial Frame Pacing Tick Generator

This block produces one pulse per serial frame time and uses that pulse to move bytes between a transmit queue, the line, an external receive source and a receive queue. The frame period comes from the peripheral clock. A power-of-four prescaler is chosen by a two-bit select. An eight-bit divisor N then stretches the frame to 32 × (N+1) prescaled steps. A select input can hand pacing to an external clock instead. In that case each rising edge of that clock makes one frame pulse.

On every frame pulse the router moves at most one byte each way. In normal mode, a byte popped from the transmit queue goes to the line. A byte from the external receive source is accepted into the receive queue. In loopback mode, the popped transmit byte is pushed directly into the receive queue, and the external source is left untouched. Whenever the prescale select, the divisor or the clock source changes value, both counters restart from zero. The next pulse then arrives one full period later.

All outputs are registered. The pulse and every transfer strobe appear in the same single cycle. The transfer decisions use the inputs sampled on the edge that ends the period.

Top module: `baud_frame_tick_gen`

## Requirements
- R1: While reset is high and on the first cycle after it, `frame_tick`, `tx_pop`, `line_valid`, `rx_in_pop` and `rx_push` are 0, and both data outputs are 0.
- R2: With the internal source, `frame_tick` is a single-cycle pulse repeating every 32 × 4^`clk_sel` × (`divisor`+1) clock cycles (`clk_sel` 0,1,2,3 gives prescale 1,4,16,64).
- R3: With `clk_sel`=0 and `divisor`=0, the first pulse comes 32 cycles after reset release (on the 32nd edge with reset low), and pulses then repeat every 32 cycles.
- R4: When `clk_sel`, `divisor` or `ext_clk_sel` differs from its value on the previous edge, both counters restart. The next pulse follows the first edge that sees the new value by exactly one new period, plus the registered output cycle.
- R5: With `ext_clk_sel`=1 the internal divider produces no pulses. One pulse is produced in the cycle after the first edge that samples `ext_clk_i` high following a low sample. Holding `ext_clk_i` high produces no further pulses.
- R6: In normal mode (`loop_en`=0), a pulse with `tx_en`=1 and `tx_avail`=1 raises `tx_pop` and `line_valid` together with `frame_tick`, and `line_data` equals the sampled `tx_data`.
- R7: `tx_pop` stays 0 on a pulse when `tx_en` is 0 or `tx_avail` is 0.
- R8: In normal mode, a pulse with `rx_en`=1 and `rx_in_avail`=1 raises `rx_in_pop` and `rx_push`, and `rx_push_data` equals the sampled `rx_in_data`. Otherwise both stay 0.
- R9: In loopback mode, a popped transmit byte is pushed with `rx_push` and `rx_push_data`=`tx_data` when `rx_en`=1. `line_valid` and `rx_in_pop` stay 0 whatever the external source offers.
- R10: In loopback mode with `rx_en`=0, the transmit byte is still popped but `rx_push` stays 0, so the byte is dropped.
- R11: `tx_pop`, `line_valid`, `rx_in_pop` and `rx_push` are never high in a cycle without `frame_tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_sel | input | 2 | Prescale select: 1, 4, 16 or 64 clocks per step |
| divisor | input | 8 | Divisor N; a frame is 32 × (N+1) steps |
| ext_clk_sel | input | 1 | 1 = pace frames from ext_clk_i |
| ext_clk_i | input | 1 | External frame clock, one frame per rising edge |
| loop_en | input | 1 | 1 = internal loopback routing |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable |
| tx_avail | input | 1 | Transmit queue holds a byte |
| tx_data | input | 8 | Head byte of the transmit queue |
| rx_in_avail | input | 1 | External receive source holds a byte |
| rx_in_data | input | 8 | Byte offered by the external source |
| frame_tick | output | 1 | One-cycle frame pulse |
| tx_pop | output | 1 | Pop the transmit queue |
| line_valid | output | 1 | line_data carries a byte to the line |
| line_data | output | 8 | Byte sent to the line |
| rx_in_pop | output | 1 | Take a byte from the external source |
| rx_push | output | 1 | Push rx_push_data into the receive queue |
| rx_push_data | output | 8 | Byte for the receive queue |

## Verification
A wrong prescaler or divisor count shows up as a change in the spacing between pulses. It is visible at the second pulse, or at the first pulse after a configuration change. A missed restart leaves the first pulse after a change early or late by the residue of the old count. A wrong routing state shows in the pulse cycle itself, as a strobe raised on the wrong side, a missing strobe, or a data byte taken from the wrong source. Stray strobes between pulses are caught on the cycle they occur.

// File: rtl/baud_tick_pkg.sv
package baud_tick_pkg;
  typedef struct packed {
    logic tx_pop;
    logic line_valid;
    logic rx_in_pop;
    logic rx_push;
  } route_t;

  // Route decision for one frame pulse.
  function automatic route_t route_of(input logic tick, input logic loop,
                                      input logic tx_on, input logic rx_on,
                                      input logic tx_has, input logic rx_has);
    route_t r;
    logic   pop;
    pop          = tick & tx_on & tx_has;
    r.tx_pop     = pop;
    r.line_valid = pop & ~loop;
    r.rx_in_pop  = tick & ~loop & rx_on & rx_has;
    r.rx_push    = loop ? (pop & rx_on) : (tick & rx_on & rx_has);
    return r;
  endfunction
endpackage

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [SEL_W-1:0] sel,
  output logic             strobe
);
  localparam int MAX_SHIFT = 2 * ((1 << SEL_W) - 1);
  localparam int CNT_W     = (MAX_SHIFT > 0) ? MAX_SHIFT : 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;

  // Limit is 4^sel - 1; the shift wraps to zero at the top select.
  always_comb begin
    limit  = (CNT_W'(1) << {sel, 1'b0}) - CNT_W'(1);
    strobe = ~restart & (cnt_q == limit);
  end

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt_q <= '0;
    end else if (strobe) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/baud_frame_counter.sv
module baud_frame_counter #(
  parameter int DIV_W      = 8,
  parameter int OVERSAMPLE = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             step,
  input  logic [DIV_W-1:0] divisor,
  output logic             wrap
);
  localparam int OS_LOG = $clog2(OVERSAMPLE);
  localparam int FC_W   = DIV_W + OS_LOG;

  logic [FC_W-1:0] cnt_q;
  logic [FC_W-1:0] limit;

  // (N+1)*OVERSAMPLE - 1, modulo arithmetic covers the top divisor.
  always_comb begin
    limit = ((FC_W'(divisor) + FC_W'(1)) << OS_LOG) - FC_W'(1);
    wrap  = ~restart & step & (cnt_q == limit);
  end

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt_q <= '0;
    end else if (wrap) begin
      cnt_q <= '0;
    end else if (step) begin
      cnt_q <= cnt_q + FC_W'(1);
    end
  end
endmodule

// File: rtl/baud_tick_router.sv
module baud_tick_router
  import baud_tick_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              loop_en,
  input  logic              tx_en,
  input  logic              rx_en,
  input  logic              tx_avail,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              rx_in_avail,
  input  logic [DATA_W-1:0] rx_in_data,
  output logic              frame_tick,
  output logic              tx_pop,
  output logic              line_valid,
  output logic [DATA_W-1:0] line_data,
  output logic              rx_in_pop,
  output logic              rx_push,
  output logic [DATA_W-1:0] rx_push_data
);
  route_t r_next;
  route_t r_q;

  always_comb begin
    r_next = route_of(tick, loop_en, tx_en, rx_en, tx_avail, rx_in_avail);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      r_q          <= '0;
      frame_tick   <= 1'b0;
      line_data    <= '0;
      rx_push_data <= '0;
    end else begin
      r_q        <= r_next;
      frame_tick <= tick;
      if (r_next.line_valid) begin
        line_data <= tx_data;
      end
      if (r_next.rx_push) begin
        rx_push_data <= loop_en ? tx_data : rx_in_data;
      end
    end
  end

  assign tx_pop     = r_q.tx_pop;
  assign line_valid = r_q.line_valid;
  assign rx_in_pop  = r_q.rx_in_pop;
  assign rx_push    = r_q.rx_push;
endmodule

// File: rtl/baud_frame_tick_gen.sv
module baud_frame_tick_gen #(
  parameter int DATA_W     = 8,
  parameter int DIV_W      = 8,
  parameter int SEL_W      = 2,
  parameter int OVERSAMPLE = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  clk_sel,
  input  logic [DIV_W-1:0]  divisor,
  input  logic              ext_clk_sel,
  input  logic              ext_clk_i,
  input  logic              loop_en,
  input  logic              tx_en,
  input  logic              rx_en,
  input  logic              tx_avail,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              rx_in_avail,
  input  logic [DATA_W-1:0] rx_in_data,
  output logic              frame_tick,
  output logic              tx_pop,
  output logic              line_valid,
  output logic [DATA_W-1:0] line_data,
  output logic              rx_in_pop,
  output logic              rx_push,
  output logic [DATA_W-1:0] rx_push_data
);
  logic [SEL_W-1:0] sel_q;
  logic [DIV_W-1:0] div_q;
  logic             src_q;
  logic             ext_lvl_q;
  logic             cfg_changed;
  logic             restart;
  logic             step;
  logic             wrap;
  logic             ext_rise;
  logic             tick_next;

  // Configuration history: any value change restarts the counters.
  always_ff @(posedge clk) begin
    sel_q     <= clk_sel;
    div_q     <= divisor;
    src_q     <= ext_clk_sel;
    ext_lvl_q <= rst ? 1'b0 : ext_clk_i;
  end

  always_comb begin
    cfg_changed = (clk_sel != sel_q) | (divisor != div_q) | (ext_clk_sel != src_q);
    restart     = cfg_changed | ext_clk_sel;
    ext_rise    = ext_clk_sel & ext_clk_i & ~ext_lvl_q;
    tick_next   = ext_clk_sel ? ext_rise : wrap;
  end

  baud_prescaler #(.SEL_W(SEL_W)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .sel     (clk_sel),
    .strobe  (step)
  );

  baud_frame_counter #(.DIV_W(DIV_W), .OVERSAMPLE(OVERSAMPLE)) u_frame (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .step    (step),
    .divisor (divisor),
    .wrap    (wrap)
  );

  baud_tick_router #(.DATA_W(DATA_W)) u_route (
    .clk          (clk),
    .rst          (rst),
    .tick         (tick_next),
    .loop_en      (loop_en),
    .tx_en        (tx_en),
    .rx_en        (rx_en),
    .tx_avail     (tx_avail),
    .tx_data      (tx_data),
    .rx_in_avail  (rx_in_avail),
    .rx_in_data   (rx_in_data),
    .frame_tick   (frame_tick),
    .tx_pop       (tx_pop),
    .line_valid   (line_valid),
    .line_data    (line_data),
    .rx_in_pop    (rx_in_pop),
    .rx_push      (rx_push),
    .rx_push_data (rx_push_data)
  );
endmodule

// File: rtl/baud_frame_tick_chk.sv
module baud_frame_tick_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              loop_en,
  input logic              tx_en,
  input logic              rx_en,
  input logic              tx_avail,
  input logic              rx_in_avail,
  input logic [DATA_W-1:0] tx_data,
  input logic              frame_tick,
  input logic              tx_pop,
  input logic              line_valid,
  input logic              rx_in_pop,
  input logic              rx_push,
  input logic [DATA_W-1:0] rx_push_data
);
  p_single_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    frame_tick |=> !frame_tick);

  p_strobe_in_tick_r11: assert property (@(posedge clk) disable iff (rst)
    (tx_pop || line_valid || rx_in_pop || rx_push) |-> frame_tick);

  p_tx_gate_r7: assert property (@(posedge clk) disable iff (rst)
    tx_pop |-> ($past(tx_en) && $past(tx_avail)));

  p_rx_gate_r8: assert property (@(posedge clk) disable iff (rst)
    (rx_in_pop) |-> ($past(rx_en) && $past(rx_in_avail) && rx_push));

  p_loop_isolated_r9: assert property (@(posedge clk) disable iff (rst)
    (frame_tick && $past(loop_en)) |-> (!line_valid && !rx_in_pop));

  p_loop_data_r9: assert property (@(posedge clk) disable iff (rst)
    (rx_push && $past(loop_en)) |-> (tx_pop && rx_push_data == $past(tx_data)));

  p_loop_drop_r10: assert property (@(posedge clk) disable iff (rst)
    (tx_pop && $past(loop_en) && !$past(rx_en)) |-> !rx_push);
endmodule

bind baud_frame_tick_gen baud_frame_tick_chk #(.DATA_W(DATA_W)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .loop_en      (loop_en),
  .tx_en        (tx_en),
  .rx_en        (rx_en),
  .tx_avail     (tx_avail),
  .rx_in_avail  (rx_in_avail),
  .tx_data      (tx_data),
  .frame_tick   (frame_tick),
  .tx_pop       (tx_pop),
  .line_valid   (line_valid),
  .rx_in_pop    (rx_in_pop),
  .rx_push      (rx_push),
  .rx_push_data (rx_push_data)
);

// File: tb/baud_frame_tick_gen_tb.sv
`timescale 1ns/1ps
module baud_frame_tick_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] clk_sel;
  logic [7:0] divisor;
  logic       ext_clk_sel, ext_clk_i, loop_en, tx_en, rx_en;
  logic       tx_avail, rx_in_avail;
  logic [7:0] tx_data, rx_in_data;
  logic       frame_tick, tx_pop, line_valid, rx_in_pop, rx_push;
  logic [7:0] line_data, rx_push_data;

  int checks = 0;
  int errors = 0;
  int stray  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  baud_frame_tick_gen dut_i (
    .clk(clk), .rst(rst), .clk_sel(clk_sel), .divisor(divisor),
    .ext_clk_sel(ext_clk_sel), .ext_clk_i(ext_clk_i), .loop_en(loop_en),
    .tx_en(tx_en), .rx_en(rx_en), .tx_avail(tx_avail), .tx_data(tx_data),
    .rx_in_avail(rx_in_avail), .rx_in_data(rx_in_data),
    .frame_tick(frame_tick), .tx_pop(tx_pop), .line_valid(line_valid),
    .line_data(line_data), .rx_in_pop(rx_in_pop), .rx_push(rx_push),
    .rx_push_data(rx_push_data)
  );

  function automatic int period_of(input int sel, input int div);
    return 32 * (1 << (2 * sel)) * (div + 1);
  endfunction

  // Expected strobes {tx_pop, line_valid, rx_in_pop, rx_push}.
  function automatic logic [3:0] exp_route(input logic lp, input logic te,
      input logic re, input logic ta, input logic ra);
    logic pop;
    pop = te & ta;
    return {pop, pop & ~lp, ~lp & re & ra, lp ? (pop & re) : (re & ra)};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_tick(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (!frame_tick && (tx_pop || line_valid || rx_in_pop || rx_push)) stray++;
    end while (!frame_tick && n < 20000);
  endtask

  task automatic set_route(input logic lp, input logic te, input logic re,
      input logic ta, input logic ra, input logic [7:0] td, input logic [7:0] rd);
    loop_en = lp; tx_en = te; rx_en = re; tx_avail = ta; rx_in_avail = ra;
    tx_data = td; rx_in_data = rd;
  endtask

  task automatic check_route(input string req);
    logic [3:0] e;
    logic [3:0] a;
    e = exp_route(loop_en, tx_en, rx_en, tx_avail, rx_in_avail);
    a = {tx_pop, line_valid, rx_in_pop, rx_push};
    check(a == e, req, a, e);
    if (e[2]) check(line_data == tx_data, {req, " line_data"}, line_data, tx_data);
    if (e[0]) check(rx_push_data == (loop_en ? tx_data : rx_in_data),
                    {req, " rx_push_data"}, rx_push_data,
                    loop_en ? tx_data : rx_in_data);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    int unsigned seed;
    seed = 32'h5eed_0042;
    void'($urandom(seed));
    rst = 1'b1; clk_sel = 2'd0; divisor = 8'd0; ext_clk_sel = 1'b0; ext_clk_i = 1'b0;
    set_route(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
    repeat (4) @(negedge clk);
    // R1 reset state
    check({frame_tick, tx_pop, line_valid, rx_in_pop, rx_push} == 5'b0, "R1 strobes",
          {frame_tick, tx_pop, line_valid, rx_in_pop, rx_push}, 0);
    check(line_data == 8'h00 && rx_push_data == 8'h00, "R1 data",
          {line_data, rx_push_data}, 0);
    rst = 1'b0;
    // R3 minimum period
    wait_tick(n); check(n == 32, "R3 first tick", n, 32);
    wait_tick(n); check(n == 32, "R3 repeat", n, 32);
    // R2 and R4 after a configuration change
    clk_sel = 2'd1; divisor = 8'd2;
    wait_tick(n); check(n == period_of(1, 2) + 1, "R4 restart", n, period_of(1, 2) + 1);
    wait_tick(n); check(n == period_of(1, 2), "R2 period", n, period_of(1, 2));
    repeat (50) @(negedge clk);
    divisor = 8'd0;
    wait_tick(n); check(n == period_of(1, 0) + 1, "R4 mid-period", n, period_of(1, 0) + 1);
    // Directed routing cases, inputs set just after a pulse
    set_route(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'hA5, 8'h3C);
    wait_tick(n); check_route("R6 R8 normal");
    set_route(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'h5A, 8'hC3);
    wait_tick(n); check_route("R9 loopback");
    set_route(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'h77, 8'h11);
    wait_tick(n); check_route("R10 loop drop");
    set_route(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h22, 8'h33);
    wait_tick(n); check_route("R7 tx disabled");
    set_route(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h44, 8'h55);
    wait_tick(n); check_route("R7 tx empty");
    // Random configurations and routing
    for (int i = 0; i < 10; i++) begin
      int s;
      int d;
      s = $urandom_range(0, 2);
      d = $urandom_range(0, 7);
      if (s == clk_sel && d == divisor) d = (d + 1) % 8;
      clk_sel = s[1:0]; divisor = d[7:0];
      wait_tick(n); check(n == period_of(s, d) + 1, "R4 random restart", n, period_of(s, d) + 1);
      set_route($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
                $urandom_range(0, 1), $urandom_range(0, 1),
                8'($urandom_range(0, 255)), 8'($urandom_range(0, 255)));
      wait_tick(n); check(n == period_of(s, d), "R2 random period", n, period_of(s, d));
      check_route("R6 R8 R9 random");
    end
    // R5 external pacing
    clk_sel = 2'd0; divisor = 8'd0;
    wait_tick(n);
    ext_clk_sel = 1'b1;
    n = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (frame_tick) n++;
    end
    check(n == 0, "R5 internal silenced", n, 0);
    ext_clk_i = 1'b1;
    @(negedge clk); check(frame_tick == 1'b1, "R5 ext edge", frame_tick, 1);
    n = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (frame_tick) n++;
    end
    check(n == 0, "R5 held high", n, 0);
    ext_clk_i = 1'b0;
    @(negedge clk);
    ext_clk_i = 1'b1;
    @(negedge clk); check(frame_tick == 1'b1, "R5 second edge", frame_tick, 1);
    ext_clk_i = 1'b0;
    ext_clk_sel = 1'b0;
    wait_tick(n); check(n == 33, "R4 source switch", n, 33);
    // R11 no strobes between pulses
    check(stray == 0, "R11 stray strobes", stray, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule